// File: doc/BRIEF.md
# GPIO Bank with Interrupt Aggregation

A bank of general-purpose pins controlled over a simple memory-mapped read/write bus. Each pin has an output-enable bit, a driven output value and a readable input level. The input level passes through a synchronizer first. Each pin can also act as an interrupt source. Its detector fires on a level or on one edge, and a polarity bit chooses which. Two independent enables gate what a trigger does. One decides whether the trigger is recorded in a sticky status bit. The other decides whether it raises the pin's own interrupt line.

A per-pin routing code decides whether the pin takes part in processor interrupt delivery. The status bits of pins that are routed to the processor and have their interrupt enabled are OR-ed into one registered summary interrupt. Software services the summary by scanning the status registers and clearing them with write-one-to-clear. There is no hardware detection of both edges. A driver that needs both edges flips the polarity after each event.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every pin reads back zero in its configuration, input/output, interrupt-configuration and status registers (with all inputs held low). Its routing code reads 7 (no destination). `pin_oe`, `pin_out`, `pin_irq` and `irq_summary` are low.
- R2: Pin i owns four word registers at byte address 0x1000 + 16*i: configuration at +0x0, input/output at +0x4, interrupt configuration at +0x8 and status at +0xC. Its routing register is at 0x400 + 4*i. Any other address reads zero, including addresses that are not word-aligned and addresses past the last pin.
- R3: Configuration bit 9 drives `pin_oe[i]`. Input/output bit 1 drives `pin_out[i]`. Input/output bit 0 reads the input after a two-flop synchronizer, so a change of `pin_in` appears there two clock edges later.
- R4: Interrupt configuration bits are: bit 0 interrupt enable, bit 1 polarity, bit 2 detect mode (1 = edge, 0 = level), bit 3 status-record enable. In level mode, a synchronized level equal to the polarity triggers. Polarity 1 means active high. The status bit then stays set after the level goes away.
- R5: In edge mode, only the transition toward the polarity level triggers: rising for polarity 1, falling for polarity 0. The opposite transition leaves status at 0.
- R6: The status-record enable alone gates whether a trigger sets status bit 0. The interrupt enable alone gates whether it raises `pin_irq[i]`. With the interrupt enable set and the status-record enable clear, `pin_irq` fires while status stays 0.
- R7: Writing 1 to status bit 0 clears it, and the clear takes priority over a trigger in the same cycle. Writing 0 has no effect. In level mode with the level still active, the bit sets again one cycle after the clear.
- R8: `irq_summary` is a register loaded with the OR, over all pins, of (status AND interrupt enable AND routing code = 4). It therefore follows a change one edge later. Routing code 7, or any code other than 4, keeps a pin out of the summary.
- R9: `pin_irq[i]` is registered from (trigger AND interrupt enable). An edge event gives a single one-cycle pulse, and an active level keeps it high for as long as the level lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, register updates on the clock edge |
| bus_rd | input | 1 | Read strobe, `bus_rdata` is zero when low |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| pin_in | input | NUM_PINS | Asynchronous pin input levels |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| pin_out | output | NUM_PINS | Per-pin driven value |
| pin_irq | output | NUM_PINS | Per-pin registered interrupt |
| irq_summary | output | 1 | Registered summary interrupt to the processor |

## Verification
The assertions take for granted that `rst_n` is held for at least one clock edge before any checking. They also assume the bus never writes and reads with conflicting expectations in the same cycle, and that `pin_in` changes only between edges. The stimulus meets these rules. Every pin change is applied at the falling clock edge, and every bus access is driven for exactly one full cycle from a falling edge. The bench sweeps every pin through every mode and polarity combination. Expected latencies are counted from the synchronizer depth, so status and `pin_irq` counts are checked at exact cycles.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
   // register map
   localparam int GRP_BASE     = 'h1000;
   localparam int GRP_STRIDE   = 16;
   localparam int ROUTE_BASE   = 'h0400;
   localparam int ROUTE_STRIDE = 4;
   // bit positions a driver relies on
   localparam int OE_BIT     = 9;
   localparam int IO_IN_BIT  = 0;
   localparam int IO_OUT_BIT = 1;
   localparam int IC_EN      = 0;
   localparam int IC_POL     = 1;
   localparam int IC_EDGE    = 2;
   localparam int IC_RAW     = 3;
   localparam int IC_W       = 4;
   localparam int ST_BIT     = 0;
   // routing codes
   localparam int ROUTE_W = 3;
   localparam logic [ROUTE_W-1:0] ROUTE_CPU  = 3'd4;
   localparam logic [ROUTE_W-1:0] ROUTE_NONE = 3'd7;

   typedef enum logic [1:0] {
      SUB_CFG  = 2'd0,
      SUB_IO   = 2'd1,
      SUB_ICFG = 2'd2,
      SUB_STAT = 2'd3
   } sub_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk)
            if (!rst_n) chain <= '0;
            else        chain <= d;
      end else begin : g_many
         always_ff @(posedge clk)
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_addr_dec.sv
`timescale 1ns/1ps
module gpio_addr_dec
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int ADDR_W   = 16,
   localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              grp_hit,
   output logic              rte_hit,
   output logic [IDX_W-1:0]  grp_idx,
   output logic [IDX_W-1:0]  rte_idx,
   output sub_e              sub
);
   localparam logic [ADDR_W-1:0] G_LO   = ADDR_W'(GRP_BASE);
   localparam logic [ADDR_W-1:0] G_SPAN = ADDR_W'(NUM_PINS * GRP_STRIDE);
   localparam logic [ADDR_W-1:0] R_LO   = ADDR_W'(ROUTE_BASE);
   localparam logic [ADDR_W-1:0] R_SPAN = ADDR_W'(NUM_PINS * ROUTE_STRIDE);

   logic [ADDR_W-1:0] goff, roff;
   logic              aligned;

   always_comb begin
      goff    = addr - G_LO;
      roff    = addr - R_LO;
      aligned = (addr[1:0] == 2'b00);
      grp_hit = aligned && (addr >= G_LO) && (goff < G_SPAN);
      rte_hit = aligned && (addr >= R_LO) && (roff < R_SPAN);
      grp_idx = goff[IDX_W+3:4];
      rte_idx = roff[IDX_W+1:2];
      sub     = sub_e'(goff[3:2]);
   end
endmodule

// File: rtl/gpio_pin_unit.sv
`timescale 1ns/1ps
module gpio_pin_unit
   import gpio_bank_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pad_in,
   input  logic               we_cfg,
   input  logic               we_io,
   input  logic               we_icfg,
   input  logic               we_stat,
   input  logic               we_route,
   input  logic               wd_oe,
   input  logic               wd_out,
   input  logic [IC_W-1:0]    wd_icfg,
   input  logic               wd_clr,
   input  logic [ROUTE_W-1:0] wd_route,
   output logic               oe,
   output logic               dout,
   output logic               level,
   output logic [IC_W-1:0]    icfg,
   output logic               status,
   output logic [ROUTE_W-1:0] route,
   output logic               irq
);
   logic sampled, prev, trig, lvl_hit, edge_hit;

   gpio_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sampled));

   always_comb begin
      lvl_hit  = icfg[IC_POL] ? sampled : ~sampled;
      edge_hit = icfg[IC_POL] ? (sampled & ~prev) : (~sampled & prev);
      trig     = icfg[IC_EDGE] ? edge_hit : lvl_hit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oe     <= 1'b0;
         dout   <= 1'b0;
         icfg   <= '0;
         route  <= ROUTE_NONE;
         status <= 1'b0;
         prev   <= 1'b0;
         irq    <= 1'b0;
      end else begin
         prev <= sampled;
         irq  <= trig & icfg[IC_EN];
         if (we_cfg)   oe    <= wd_oe;
         if (we_io)    dout  <= wd_out;
         if (we_icfg)  icfg  <= wd_icfg;
         if (we_route) route <= wd_route;
         if (we_stat && wd_clr)       status <= 1'b0;
         else if (trig && icfg[IC_RAW]) status <= 1'b1;
      end
   end

   assign level = sampled;
endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS    = 8,
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_irq,
   output logic                irq_summary
);
   localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

   generate
      if (NUM_PINS < 1 || NUM_PINS > 64) begin : g_bad_pins
         $error("NUM_PINS must lie in 1..64");
      end
      if (DATA_W < OE_BIT + 1) begin : g_bad_data
         $error("DATA_W too narrow for the configuration register");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (GRP_BASE + NUM_PINS * GRP_STRIDE > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W cannot reach the last pin group");
      end
   endgenerate

   logic             grp_hit, rte_hit;
   logic [IDX_W-1:0] grp_idx, rte_idx;
   sub_e             sub;

   gpio_addr_dec #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_dec (
      .addr(bus_addr), .grp_hit(grp_hit), .rte_hit(rte_hit),
      .grp_idx(grp_idx), .rte_idx(rte_idx), .sub(sub));

   logic [NUM_PINS-1:0] level_v, status_v, clr_req_v;
   logic [NUM_PINS-1:0] int_en_v, raw_en_v, route_cpu_v, qual_v;
   logic [IC_W-1:0]     icfg_v  [NUM_PINS];
   logic [ROUTE_W-1:0]  route_v [NUM_PINS];

   genvar gi;
   generate
      for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
         logic sel_g, we_cfg, we_io, we_icfg, we_stat, we_route;
         assign sel_g    = bus_wr && grp_hit && (grp_idx == IDX_W'(gi));
         assign we_cfg   = sel_g && (sub == SUB_CFG);
         assign we_io    = sel_g && (sub == SUB_IO);
         assign we_icfg  = sel_g && (sub == SUB_ICFG);
         assign we_stat  = sel_g && (sub == SUB_STAT);
         assign we_route = bus_wr && rte_hit && (rte_idx == IDX_W'(gi));

         gpio_pin_unit #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
            .clk(clk), .rst_n(rst_n), .pad_in(pin_in[gi]),
            .we_cfg(we_cfg), .we_io(we_io), .we_icfg(we_icfg),
            .we_stat(we_stat), .we_route(we_route),
            .wd_oe(bus_wdata[OE_BIT]), .wd_out(bus_wdata[IO_OUT_BIT]),
            .wd_icfg(bus_wdata[IC_W-1:0]), .wd_clr(bus_wdata[ST_BIT]),
            .wd_route(bus_wdata[ROUTE_W-1:0]),
            .oe(pin_oe[gi]), .dout(pin_out[gi]), .level(level_v[gi]),
            .icfg(icfg_v[gi]), .status(status_v[gi]), .route(route_v[gi]),
            .irq(pin_irq[gi]));

         assign clr_req_v[gi]   = we_stat && bus_wdata[ST_BIT];
         assign int_en_v[gi]    = icfg_v[gi][IC_EN];
         assign raw_en_v[gi]    = icfg_v[gi][IC_RAW];
         assign route_cpu_v[gi] = (route_v[gi] == ROUTE_CPU);
         assign qual_v[gi]      = status_v[gi] & int_en_v[gi] & route_cpu_v[gi];
      end
   endgenerate

   always_ff @(posedge clk)
      if (!rst_n) irq_summary <= 1'b0;
      else        irq_summary <= |qual_v;

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (grp_hit) begin
            case (sub)
               SUB_CFG:  bus_rdata[OE_BIT] = pin_oe[grp_idx];
               SUB_IO: begin
                  bus_rdata[IO_IN_BIT]  = level_v[grp_idx];
                  bus_rdata[IO_OUT_BIT] = pin_out[grp_idx];
               end
               SUB_ICFG: bus_rdata[IC_W-1:0] = icfg_v[grp_idx];
               SUB_STAT: bus_rdata[ST_BIT] = status_v[grp_idx];
               default:  bus_rdata = '0;
            endcase
         end else if (rte_hit) begin
            bus_rdata[ROUTE_W-1:0] = route_v[rte_idx];
         end
      end
   end
endmodule

// File: rtl/gpio_bank_chk.sv
`timescale 1ns/1ps
module gpio_bank_chk #(
   parameter int NUM_PINS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_PINS-1:0] clr_req,
   input logic [NUM_PINS-1:0] status,
   input logic [NUM_PINS-1:0] int_en,
   input logic [NUM_PINS-1:0] raw_en,
   input logic [NUM_PINS-1:0] route_cpu,
   input logic [NUM_PINS-1:0] pin_irq,
   input logic                irq_summary
);
   genvar gi;
   generate
      for (gi = 0; gi < NUM_PINS; gi++) begin : g_chk
         // R7: a clear request always wins over a concurrent trigger
         p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            clr_req[gi] |=> !status[gi]);
         // R6: status only rises while recording is enabled
         p_status_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[gi]) |-> $past(raw_en[gi]));
         // R6: per-pin interrupt only while its enable was set
         p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
            pin_irq[gi] |-> $past(int_en[gi]));
      end
   endgenerate

   // R8: with no pin routed to the processor the summary stays low
   p_unrouted_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (route_cpu == '0) |=> !irq_summary);

   // R8: with no recorded status anywhere the summary stays low
   p_no_status_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (status == '0) |=> !irq_summary);
endmodule

bind gpio_irq_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr_req(clr_req_v), .status(status_v),
   .int_en(int_en_v), .raw_en(raw_en_v), .route_cpu(route_cpu_v),
   .pin_irq(pin_irq), .irq_summary(irq_summary));

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;
   localparam int NP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [15:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0, bus_rdata;
   logic [NP-1:0] pin_in = '0, pin_oe, pin_out, pin_irq;
   logic          irq_summary;

   int total = 0, bad = 0;
   int irq_cnt [NP];

   always #10 clk = ~clk;   // 50 MHz

   gpio_irq_bank #(.NUM_PINS(NP)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
      .pin_irq(pin_irq), .irq_summary(irq_summary));

   initial for (int i = 0; i < NP; i++) irq_cnt[i] = 0;
   always @(posedge clk)
      for (int i = 0; i < NP; i++) if (pin_irq[i]) irq_cnt[i] = irq_cnt[i] + 1;

   function automatic int ga(int p, int s); return 'h1000 + 16*p + 4*s; endfunction
   function automatic int ra(int p); return 'h400 + 4*p; endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wcyc(int n); repeat (n) @(negedge clk); endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 16'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = 16'(a);
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic finish_run;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      int c0;
      wcyc(4);
      rst_n = 1'b1;
      wcyc(1);

      // R1 reset values
      for (int p = 0; p < NP; p++) begin
         for (int s = 0; s < 4; s++) begin
            rd(ga(p, s), v); chk("R1 pin reg", v, 32'h0);
         end
         rd(ra(p), v); chk("R1 route", v, 32'h7);
      end
      chk("R1 outputs", {pin_oe, pin_out, pin_irq, 3'b0, irq_summary}, '0);

      // R2 unmapped reads
      rd('h0000, v);            chk("R2 low", v, 0);
      rd('h1000 + 16*NP, v);    chk("R2 past grp", v, 0);
      rd('h400 + 4*NP, v);      chk("R2 past route", v, 0);
      rd('h402, v);             chk("R2 misaligned route", v, 0);
      rd('h1005, v);            chk("R2 misaligned grp", v, 0);

      // R3 output enable, drive value, synchronized input
      for (int p = 0; p < NP; p++) begin
         wr(ga(p, 0), (p % 2 == 0) ? 32'h200 : 32'h0);
         wr(ga(p, 1), 32'h2);
      end
      chk("R3 pin_oe", 32'(pin_oe), 32'h5);
      chk("R3 pin_out", 32'(pin_out), 32'hF);
      rd(ga(0, 0), v); chk("R3 cfg readback", v, 32'h200);
      pin_in = 4'b1010;
      wcyc(1);
      rd(ga(1, 1), v); chk("R3 input after one edge", v, 32'h2);
      wcyc(1);
      rd(ga(1, 1), v); chk("R3 input after two edges", v, 32'h3);
      rd(ga(2, 1), v); chk("R3 low input", v, 32'h2);
      pin_in = '0;
      wcyc(3);

      // R4 R5 R7 R8 R9 sweep over pins, modes and polarities
      for (int p = 0; p < NP; p++) begin
         for (int m = 0; m < 2; m++) begin
            for (int pol = 0; pol < 2; pol++) begin
               logic idle;
               string rq;
               idle = ~pol[0];
               rq = (m == 1) ? "R5" : "R4";
               pin_in[p] = idle;
               wcyc(4);
               wr(ra(p), 32'h4);
               wr(ga(p, 2), 32'(1 | (pol << 1) | (m << 2) | 8));
               wr(ga(p, 3), 32'h1);
               wcyc(2);
               rd(ga(p, 3), v); chk({rq, " idle status"}, v, 0);
               c0 = irq_cnt[p];
               pin_in[p] = pol[0];
               wcyc(6);
               rd(ga(p, 3), v); chk({rq, " trigger status"}, v, 1);
               chk("R8 summary set", 32'(irq_summary), 1);
               chk("R9 irq cycles", 32'(irq_cnt[p] - c0), (m == 1) ? 1 : 3);
               wr(ga(p, 3), 32'h1);
               rd(ga(p, 3), v); chk("R7 clear wins", v, 0);
               wcyc((m == 1) ? 2 : 1);
               rd(ga(p, 3), v); chk("R7 after clear", v, (m == 1) ? 0 : 1);
               pin_in[p] = idle;
               wcyc(4);
               rd(ga(p, 3), v);
               chk((m == 1) ? "R5 opposite edge" : "R4 latched", v, (m == 1) ? 0 : 1);
               wr(ga(p, 3), 32'h1);
               wcyc(2);
               rd(ga(p, 3), v); chk("R7 final clear", v, 0);
               chk("R8 summary cleared", 32'(irq_summary), 0);
               wr(ga(p, 2), 32'h0);
            end
         end
      end

      // R6 interrupt without status record
      pin_in[0] = 1'b0;
      wcyc(4);
      wr(ra(0), 32'h4);
      wr(ga(0, 2), 32'h7);
      c0 = irq_cnt[0];
      pin_in[0] = 1'b1;
      wcyc(6);
      chk("R6 irq without status", 32'(irq_cnt[0] - c0), 1);
      rd(ga(0, 3), v); chk("R6 status unrecorded", v, 0);
      chk("R6 summary quiet", 32'(irq_summary), 0);
      pin_in[0] = 1'b0;
      wcyc(4);

      // R6 status without interrupt, R8 enable and routing gates
      wr(ga(0, 2), 32'hE);
      wr(ga(0, 3), 32'h1);
      c0 = irq_cnt[0];
      pin_in[0] = 1'b1;
      wcyc(6);
      rd(ga(0, 3), v); chk("R6 status recorded", v, 1);
      chk("R6 irq suppressed", 32'(irq_cnt[0] - c0), 0);
      chk("R8 summary needs enable", 32'(irq_summary), 0);
      wr(ga(0, 2), 32'hF);
      wcyc(2);
      chk("R8 summary enabled", 32'(irq_summary), 1);
      wr(ra(0), 32'h7);
      wcyc(2);
      chk("R8 route none", 32'(irq_summary), 0);
      rd(ra(0), v); chk("R2 route readback", v, 32'h7);

      // R7 writing zero leaves status alone
      wr(ga(0, 3), 32'h0);
      rd(ga(0, 3), v); chk("R7 write zero", v, 1);
      wr(ga(0, 3), 32'hFFFF_FFFE);
      rd(ga(0, 3), v); chk("R7 write upper bits", v, 1);
      wr(ga(0, 3), 32'h1);
      rd(ga(0, 3), v); chk("R7 write one", v, 0);
      pin_in = '0;
      wcyc(4);

      finish_run();
   end
endmodule